// File: doc/BRIEF.md
# Charge-Balance Single-Slope ADC Sequencer

This block is the digital sequencer of a two-phase integrating converter. When a conversion is requested, it waits a programmable settling time. It then opens the analog input to an external integrator for a fixed charge-balance window. During that window it meters reference-current packets back into the integrator, clocked by a divided feedback clock, and counts every clock cycle in which the feedback gate is open. This gives a coarse count.

After the window it closes the input and enables a constant-current discharge of the integrator. It counts clock cycles until the zero-crossing comparator falls, which gives the fine residue. The signed reading is the coarse count scaled by a fixed number of fine steps per coarse step, minus the fine count, minus the offset that belongs to the selected input range.

The range input picks between the bipolar offset used for voltage and current and the larger offset used for resistance. That choice is captured when the conversion is accepted and is presented on the offset-select output until the conversion ends. A discharge that never crosses zero within a bounded number of cycles ends the conversion with an error flag. The analog integrator, the references, the input multiplexer and the protection circuits sit outside the block.

Top module: `cbss_adc_ctrl`

## Requirements
- R1: After reset, and whenever the sequencer is idle, the outputs in_en_o, fb_gate_o, slope_en_o, ofs_sel_o, busy_o and valid_o are all low.
- R2: A start accepted on clock edge E0 causes in_en_o to rise on edge E(S+1), where S is the value of settle_i captured at E0.
- R3: in_en_o stays high for exactly BAL_CYCLES clock cycles. slope_en_o rises on the edge where in_en_o falls. The two outputs are never high together.
- R4: The feedback gate is re-decided only at the start of each CLK_DIV-cycle feedback period, counting from the first balance cycle. At that point it takes the synchronised balance comparator level (high means charge is fed back). It holds for the rest of the period and is never high outside the balance window.
- R5: The coarse count equals the number of clock cycles with fb_gate_o high. With an integrating input, the coarse count therefore tracks input rate × BAL_CYCLES / feedback current.
- R6: Both comparator inputs pass through a two-flop synchroniser. If cmp_run_i is lowered after the K-th clock edge of the discharge phase (counting its entry edge as edge 0), the fine count is K+2 and valid_o rises on edge K+3.
- R7: On completion, result_o (two's complement, RES_W bits) equals coarse × FINE_PER_COARSE − fine − offset. It is registered together with the one-cycle valid_o strobe and held until the next completion.
- R8: range_ohm_i is captured when a start is accepted: 1 selects OFFSET_OHM, 0 selects OFFSET_VI. ofs_sel_o shows the captured value throughout the conversion, and later changes on range_ohm_i have no effect on that conversion.
- R9: If cmp_run_i stays high until the fine count reaches MAX_RUN, the next edge ends the conversion. In that case err_o goes high, result_o is 0 and the discharge lasted MAX_RUN+1 cycles. err_o clears when the next start is accepted.
- R10: A start while busy_o is high is ignored. busy_o stays high from the accepting edge through the cycle in which valid_o is high, and falls one cycle later. valid_o is high for one cycle per conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Conversion request, accepted only when idle |
| settle_i | input | SETTLE_W | Settling delay in clock cycles |
| range_ohm_i | input | 1 | 1 selects the resistance range offset, 0 the voltage/current offset |
| cmp_bal_i | input | 1 | Balance-threshold comparator (asynchronous) |
| cmp_run_i | input | 1 | Discharge zero-crossing comparator (asynchronous) |
| in_en_o | output | 1 | Connects the signal to the integrator during balance |
| ofs_sel_o | output | 1 | Selects the large input offset for the whole conversion |
| fb_gate_o | output | 1 | Switches the feedback reference current into the integrator |
| slope_en_o | output | 1 | Enables the constant-current discharge |
| busy_o | output | 1 | Conversion in progress |
| valid_o | output | 1 | One-cycle strobe marking a new result |
| result_o | output | RES_W | Signed reading |
| err_o | output | 1 | Discharge timeout flag for the latest conversion |

## Verification
The bench builds the sequencer with CLK_DIV 4, BAL_CYCLES 64, MAX_RUN 40, FINE_PER_COARSE 8 and offsets 100 and 300. With these values a full balance window, a timed-out discharge and a complete signed result fit in a few hundred cycles, and exact expected readings are easy to compute. Full-scale and zero-scale comparator levels give exact coarse counts. A behavioural integrator fed by the gate output shows that the charge-balance loop converges and that the gate changes only at period boundaries. Controlled drop points on the discharge comparator expose the synchroniser latency, and holding that comparator high drives the timeout path.

// File: rtl/cbss_pkg.sv
// Shared definitions for the charge-balance single-slope sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package cbss_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SETTLE  = 3'd1,
        ST_BALANCE = 3'd2,
        ST_RUNDOWN = 3'd3,
        ST_DONE    = 3'd4
    } cbss_state_e;

endpackage

// File: rtl/cbss_sync.sv
// Two-flop synchroniser, one chain per bit.
// Does: brings asynchronous comparator levels into the clock domain.
// Assumes: inputs are level signals; two cycles of latency are acceptable.
module cbss_sync #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            logic meta_q;
            logic stab_q;

            // Two-stage capture of one asynchronous bit.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q <= 1'b0;
                    stab_q <= 1'b0;
                end else begin
                    meta_q <= d_i[b];
                    stab_q <= meta_q;
                end
            end

            assign q_o[b] = stab_q;
        end
    endgenerate

endmodule

// File: rtl/cbss_balance.sv
// Charge-balance phase engine.
// Does: times the fixed balance window, divides the clock into feedback
//       periods, decides the feedback gate at the first cycle of each
//       period from the synchronised comparator, and counts gate-high cycles.
// Assumes: CLK_DIV >= 2, BAL_CYCLES >= 2; run_i is high for exactly the
//          balance window and low otherwise; clear_i pulses at start accept.
module cbss_balance #(
    parameter int CLK_DIV    = 16,
    parameter int BAL_CYCLES = 1_000_000,
    parameter int COARSE_W   = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear_i,
    input  logic                run_i,
    input  logic                cmp_i,
    output logic                gate_o,
    output logic                last_o,
    output logic [COARSE_W-1:0] coarse_o
);

    localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam int TMR_W = (BAL_CYCLES > 1) ? $clog2(BAL_CYCLES) : 1;

    logic [DIV_W-1:0]    div_q;
    logic [TMR_W-1:0]    tmr_q;
    logic                hold_q;
    logic [COARSE_W-1:0] coarse_q;
    logic                period_start;
    logic                gate_now;

    // Gate decision: fresh comparator level at a period start, else held.
    always_comb begin
        period_start = (div_q == '0);
        gate_now     = period_start ? cmp_i : hold_q;
        gate_o       = run_i & gate_now;
        last_o       = run_i & (tmr_q == TMR_W'(BAL_CYCLES - 1));
    end

    // Feedback-period divider, window timer and held gate level.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            div_q  <= '0;
            tmr_q  <= '0;
            hold_q <= 1'b0;
        end else begin
            div_q  <= (div_q == DIV_W'(CLK_DIV - 1)) ? '0 : div_q + 1'b1;
            tmr_q  <= tmr_q + 1'b1;
            hold_q <= gate_now;
        end
    end

    // Coarse counter: one count per clock with the feedback gate open.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            coarse_q <= '0;
        end else if (gate_o) begin
            coarse_q <= coarse_q + 1'b1;
        end
    end

    assign coarse_o = coarse_q;

    // R5: the coarse count can never exceed the window length.
    assert_coarse_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        coarse_q <= COARSE_W'(BAL_CYCLES));

    // R4: inside a period the gate keeps the level it took at the period start.
    assert_gate_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && $past(run_i) && div_q != '0) |-> (gate_o == $past(gate_o)));

endmodule

// File: rtl/cbss_rundown.sv
// Single-slope discharge counter.
// Does: counts clocks while the synchronised zero-crossing comparator is
//       high, flags the first low reading, and flags expiry at MAX_RUN.
// Assumes: run_i is high only during the discharge phase; clear_i pulses
//          at start accept.
module cbss_rundown #(
    parameter int MAX_RUN = 4096,
    parameter int FINE_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              run_i,
    input  logic              cmp_i,
    output logic              stop_o,
    output logic              expire_o,
    output logic [FINE_W-1:0] fine_o
);

    logic [FINE_W-1:0] fine_q;
    logic              full;

    // End-of-discharge detection: crossing seen, or limit reached.
    always_comb begin
        full     = (fine_q == FINE_W'(MAX_RUN));
        stop_o   = run_i & ~cmp_i;
        expire_o = run_i & cmp_i & full;
    end

    // Fine counter: advance while the integrator has not crossed zero.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            fine_q <= '0;
        end else if (run_i && cmp_i && !full) begin
            fine_q <= fine_q + 1'b1;
        end
    end

    assign fine_o = fine_q;

    // R9: the fine count is capped at the timeout limit.
    assert_fine_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fine_q <= FINE_W'(MAX_RUN));

    // R6: the fine count moves only during the discharge or on clear.
    assert_fine_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !clear_i) |=> $stable(fine_q));

endmodule

// File: rtl/cbss_adc_ctrl.sv
// Charge-balance single-slope ADC sequencer (top).
// Does: sequences IDLE -> SETTLE -> BALANCE -> RUNDOWN -> DONE, drives the
//       integrator control lines, and forms the signed reading from the
//       coarse and fine counts and the captured range offset.
// Assumes: comparator inputs are asynchronous; start_i is a level or pulse
//          sampled only in IDLE; parameters obey the submodule assumptions.
module cbss_adc_ctrl
    import cbss_pkg::*;
#(
    parameter int CLK_DIV         = 16,
    parameter int BAL_CYCLES      = 1_000_000,
    parameter int SETTLE_W        = 16,
    parameter int MAX_RUN         = 4096,
    parameter int FINE_PER_COARSE = 64,
    parameter int RES_W           = 32,
    parameter int OFFSET_VI       = 32_000_000,
    parameter int OFFSET_OHM      = 48_000_000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [SETTLE_W-1:0]     settle_i,
    input  logic                    range_ohm_i,
    input  logic                    cmp_bal_i,
    input  logic                    cmp_run_i,
    output logic                    in_en_o,
    output logic                    ofs_sel_o,
    output logic                    fb_gate_o,
    output logic                    slope_en_o,
    output logic                    busy_o,
    output logic                    valid_o,
    output logic signed [RES_W-1:0] result_o,
    output logic                    err_o
);

    localparam int COARSE_W = $clog2(BAL_CYCLES + 1);
    localparam int FINE_W   = $clog2(MAX_RUN + 1);
    localparam logic signed [RES_W-1:0] FPC_R     = RES_W'(FINE_PER_COARSE);
    localparam logic signed [RES_W-1:0] OFS_VI_R  = RES_W'(OFFSET_VI);
    localparam logic signed [RES_W-1:0] OFS_OHM_R = RES_W'(OFFSET_OHM);

    cbss_state_e             state_q, state_d;
    logic [SETTLE_W-1:0]     settle_lat_q, settle_cnt_q;
    logic                    range_q;
    logic                    err_q;
    logic signed [RES_W-1:0] result_q, calc;
    logic [1:0]              cmp_s;
    logic                    accept, in_bal, in_run;
    logic                    bal_gate, bal_last;
    logic [COARSE_W-1:0]     coarse;
    logic                    run_stop, run_expire;
    logic [FINE_W-1:0]       fine;

    cbss_sync #(.WIDTH(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({cmp_run_i, cmp_bal_i}),
        .q_o   (cmp_s)
    );

    // Phase qualifiers shared by the engines and the outputs.
    always_comb begin
        accept = (state_q == ST_IDLE) && start_i;
        in_bal = (state_q == ST_BALANCE);
        in_run = (state_q == ST_RUNDOWN);
    end

    cbss_balance #(
        .CLK_DIV    (CLK_DIV),
        .BAL_CYCLES (BAL_CYCLES),
        .COARSE_W   (COARSE_W)
    ) u_balance (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (accept),
        .run_i    (in_bal),
        .cmp_i    (cmp_s[0]),
        .gate_o   (bal_gate),
        .last_o   (bal_last),
        .coarse_o (coarse)
    );

    cbss_rundown #(
        .MAX_RUN (MAX_RUN),
        .FINE_W  (FINE_W)
    ) u_rundown (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (accept),
        .run_i    (in_run),
        .cmp_i    (cmp_s[1]),
        .stop_o   (run_stop),
        .expire_o (run_expire),
        .fine_o   (fine)
    );

    // Next-state decision for the conversion sequence.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:    if (start_i) state_d = ST_SETTLE;
            ST_SETTLE:  if (settle_cnt_q == settle_lat_q) state_d = ST_BALANCE;
            ST_BALANCE: if (bal_last) state_d = ST_RUNDOWN;
            ST_RUNDOWN: if (run_stop || run_expire) state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Settling delay: capture the length at accept, count through SETTLE.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            settle_lat_q <= '0;
            settle_cnt_q <= '0;
        end else if (accept) begin
            settle_lat_q <= settle_i;
            settle_cnt_q <= '0;
        end else if (state_q == ST_SETTLE) begin
            settle_cnt_q <= settle_cnt_q + 1'b1;
        end
    end

    // Range capture for the whole conversion.
    always_ff @(posedge clk) begin
        if (!rst_n)      range_q <= 1'b0;
        else if (accept) range_q <= range_ohm_i;
    end

    // Reading arithmetic: scaled coarse count minus residue minus offset.
    always_comb begin
        calc = $signed(RES_W'(coarse)) * FPC_R
             - $signed(RES_W'(fine))
             - (range_q ? OFS_OHM_R : OFS_VI_R);
    end

    // Result and error registers, updated on the edge entering DONE.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            err_q    <= 1'b0;
        end else if (accept) begin
            err_q <= 1'b0;
        end else if (in_run && run_expire) begin
            result_q <= '0;
            err_q    <= 1'b1;
        end else if (in_run && run_stop) begin
            result_q <= calc;
        end
    end

    assign in_en_o    = in_bal;
    assign slope_en_o = in_run;
    assign fb_gate_o  = bal_gate;
    assign ofs_sel_o  = range_q & (state_q != ST_IDLE);
    assign busy_o     = (state_q != ST_IDLE);
    assign valid_o    = (state_q == ST_DONE);
    assign result_o   = result_q;
    assign err_o      = err_q;

    // R1: every analog control line is quiet while idle.
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !(in_en_o | fb_gate_o | slope_en_o | ofs_sel_o | valid_o));

    // R2: input enable rises only at the end of the settling phase.
    assert_settle_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_en_o) |-> ($past(state_q) == ST_SETTLE));

    // R3: input path and discharge path are never enabled together.
    assert_phase_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_en_o && slope_en_o));

    // R3: the discharge starts immediately when the balance window closes.
    assert_rundown_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_en_o) |-> slope_en_o);

    // R8: the offset selection cannot change inside a conversion.
    assert_range_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !valid_o) |=> $stable(ofs_sel_o));

    // R10: valid is a single-cycle strobe.
    assert_valid_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R10: busy cannot drop before the valid strobe.
    assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !valid_o) |=> busy_o);

    // R9: the error flag appears only together with a completion strobe.
    assert_err_with_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> valid_o);

endmodule

// File: tb/test_cbss_adc_ctrl.sv
module test_cbss_adc_ctrl;

    localparam int CLK_DIV = 4;
    localparam int BAL     = 64;
    localparam int SW      = 8;
    localparam int MAXR    = 40;
    localparam int FPC     = 8;
    localparam int RW      = 24;
    localparam int OVI     = 100;
    localparam int OOHM    = 300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [SW-1:0] settle_i = '0;
    logic range_ohm_i = 1'b0;
    logic cmp_bal_i = 1'b0;
    logic cmp_run_i = 1'b1;
    logic in_en_o, ofs_sel_o, fb_gate_o, slope_en_o, busy_o, valid_o, err_o;
    logic signed [RW-1:0] result_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    bit model_on = 0;
    int vint = 0;

    int r_settle, r_bal, r_gate, r_hold, r_run, r_res;
    int r_ofs_bad, r_busy_gap;
    bit r_err, r_err_acc, r_valid_now, r_valid_next, r_busy_next;

    always #5 clk = ~clk;

    cbss_adc_ctrl #(
        .CLK_DIV(CLK_DIV), .BAL_CYCLES(BAL), .SETTLE_W(SW), .MAX_RUN(MAXR),
        .FINE_PER_COARSE(FPC), .RES_W(RW), .OFFSET_VI(OVI), .OFFSET_OHM(OOHM)
    ) i_cbss_adc_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .settle_i(settle_i),
        .range_ohm_i(range_ohm_i), .cmp_bal_i(cmp_bal_i), .cmp_run_i(cmp_run_i),
        .in_en_o(in_en_o), .ofs_sel_o(ofs_sel_o), .fb_gate_o(fb_gate_o),
        .slope_en_o(slope_en_o), .busy_o(busy_o), .valid_o(valid_o),
        .result_o(result_o), .err_o(err_o)
    );

    // Behavioural integrator: input charge in, feedback packets out.
    always @(negedge clk) begin
        if (model_on) begin
            if (in_en_o)   vint = vint + 3;
            if (fb_gate_o) vint = vint - 8;
            cmp_bal_i = (vint > 0);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input int act, input int exp);
        chk(act == exp, tag, act, exp);
    endtask

    // Runs one conversion; k < 0 keeps the discharge comparator high.
    task automatic convert(input int settle, input bit ohm, input int k, input bit poke);
        int  n;
        bit  prev;
        @(negedge clk);
        settle_i = SW'(settle);
        range_ohm_i = ohm;
        cmp_run_i = 1'b1;
        start_i = 1'b1;
        r_ofs_bad = 0; r_busy_gap = 0; r_bal = 0; r_gate = 0; r_hold = 0; r_run = 0;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 1) begin
                start_i = 1'b0;
                r_err_acc = err_o;
            end
            if (!busy_o) r_busy_gap++;
            if (ofs_sel_o != ohm) r_ofs_bad++;
        end while (!in_en_o && n < 500);
        r_settle = n;
        prev = 1'b0;
        while (in_en_o && r_bal < 500) begin
            if (fb_gate_o) r_gate++;
            if ((r_bal % CLK_DIV) != 0 && fb_gate_o != prev) r_hold++;
            prev = fb_gate_o;
            if (poke && r_bal == 10) begin
                start_i = 1'b1;
                range_ohm_i = !ohm;
            end
            if (poke && r_bal == 11) start_i = 1'b0;
            r_bal++;
            @(negedge clk);
            if (!busy_o) r_busy_gap++;
            if (ofs_sel_o != ohm) r_ofs_bad++;
        end
        while (slope_en_o && r_run < 500) begin
            r_run++;
            if (k >= 0 && r_run == k + 1) cmp_run_i = 1'b0;
            @(negedge clk);
            if (!busy_o) r_busy_gap++;
            if (ofs_sel_o != ohm) r_ofs_bad++;
        end
        r_res = int'(result_o);
        r_err = err_o;
        r_valid_now = valid_o;
        @(negedge clk);
        r_valid_next = valid_o;
        r_busy_next = busy_o;
        cmp_run_i = 1'b1;
        range_ohm_i = 1'b0;
    endtask

    task automatic t_reset;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_eq("R1 reset outputs", int'({in_en_o, fb_gate_o, slope_en_o, ofs_sel_o, busy_o, valid_o}), 0);
        chk_eq("R1 reset result", int'(result_o), 0);
    endtask

    task automatic t_full_scale;
        cmp_bal_i = 1'b1;
        repeat (3) @(negedge clk);
        convert(0, 1'b0, 5, 1'b0);
        chk_eq("R2 settle 0 timing", r_settle, 2);
        chk_eq("R3 balance length", r_bal, BAL);
        chk_eq("R4 gate cycles full scale", r_gate, BAL);
        chk_eq("R6 discharge length k=5", r_run, 8);
        chk_eq("R7 full scale result", r_res, BAL * FPC - 7 - OVI);
        chk_eq("R7 valid at completion", int'(r_valid_now), 1);
        chk_eq("R1 idle after conversion", int'({in_en_o, fb_gate_o, slope_en_o, ofs_sel_o, busy_o, valid_o}), 0);
    endtask

    task automatic t_zero_scale;
        cmp_bal_i = 1'b0;
        repeat (3) @(negedge clk);
        convert(2, 1'b1, 3, 1'b0);
        chk_eq("R2 settle 2 timing", r_settle, 4);
        chk_eq("R4 gate cycles zero scale", r_gate, 0);
        chk_eq("R6 discharge length k=3", r_run, 6);
        chk_eq("R8 resistance offset result", r_res, -5 - OOHM);
        chk_eq("R8 offset select held", r_ofs_bad, 0);
    endtask

    task automatic t_integrator;
        int coarse;
        int rem;
        vint = 0;
        model_on = 1'b1;
        repeat (3) @(negedge clk);
        convert(1, 1'b0, 2, 1'b0);
        model_on = 1'b0;
        rem = (r_res + 4 + OVI) % FPC;
        coarse = (r_res + 4 + OVI) / FPC;
        chk_eq("R5 result has fine residue 4", rem, 0);
        chk((coarse >= 14) && (coarse <= 34), "R5 coarse tracks input", coarse, 24);
        chk_eq("R4 gate changes only at period start", r_hold, 0);
    endtask

    task automatic t_timeout;
        cmp_bal_i = 1'b1;
        repeat (3) @(negedge clk);
        convert(0, 1'b0, -1, 1'b0);
        chk_eq("R9 timeout discharge length", r_run, MAXR + 1);
        chk_eq("R9 error flag", int'(r_err), 1);
        chk_eq("R9 timeout result", r_res, 0);
    endtask

    task automatic t_busy_start;
        cmp_bal_i = 1'b1;
        repeat (3) @(negedge clk);
        convert(3, 1'b0, 0, 1'b1);
        chk_eq("R9 error cleared at accept", int'(r_err_acc), 0);
        chk_eq("R9 error stays clear", int'(r_err), 0);
        chk_eq("R2 settle 3 timing", r_settle, 5);
        chk_eq("R8 range latched despite change", r_res, BAL * FPC - 2 - OVI);
        chk_eq("R8 offset select ignores change", r_ofs_bad, 0);
        chk_eq("R10 busy held through conversion", r_busy_gap, 0);
        chk_eq("R10 valid single cycle", int'(r_valid_next), 0);
        chk_eq("R10 busy drops after valid", int'(r_busy_next), 0);
        chk_eq("R10 extra start ignored", int'(busy_o), 0);
        chk_eq("R6 discharge length k=0", r_run, 3);
    endtask

    initial begin
        t_reset();
        t_full_scale();
        t_zero_scale();
        t_integrator();
        t_timeout();
        t_busy_start();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule